// File: doc/BRIEF.md
# Tagged Next-Line Prefetch Controller

This block is the tag side of a small direct-mapped cache with a next-line prefetcher built in. Besides its address tag, each line keeps a single "armed" bit. A line that arrives because of a demand miss is stored armed. A line that arrives because of a prefetch is stored unarmed. When a line goes from unarmed to armed, the block schedules a request for the neighbouring line. This happens either when a demand fill installs the line or when the first reference hits a prefetched line. As a result, a run of accesses to consecutive lines keeps pulling the next line in ahead of use.

Addresses on every port are line addresses. The block reports hit or miss for each access and emits a demand miss request. It offers prefetch requests through a valid/ready channel that shares the memory path with the miss requests and always yields to them. It remembers which requests are still in flight, so the same line is not requested twice. A second per-line bit records the stream direction, which lets a chain walk downward through memory as well as upward.

Top module: `nlp_prefetch`

## Requirements
- R1: After reset, `res_valid`, `miss_valid` and `pf_valid` are 0, no line is present, and every armed bit is 0.
- R2: One cycle after an access, `res_valid` is 1 and `res_hit` tells whether the line was present. On a miss, `miss_valid` pulses for that one cycle and `miss_line` carries the access line.
- R3: A fill with `fill_is_pf`=0 and `fill_err`=0 installs its line armed. If the neighbour line is absent and not in flight, `pf_valid` rises in the next cycle with `pf_line` set to the neighbour.
- R4: A fill with `fill_is_pf`=1 installs its line unarmed and triggers nothing. The first later hit on that line triggers a prefetch of its neighbour, visible in the cycle after the access. Further hits trigger nothing.
- R5: No prefetch is issued for a neighbour line that is already present.
- R6: No prefetch is issued for a line with an outstanding demand or prefetch request. Any fill response for that line, including an erroneous one, ends the outstanding state.
- R7: A fill with `fill_err`=1 installs nothing and produces no request.
- R8: A fill into an index that holds a different line replaces that line. The new line's armed bit is set by the fill's source, never carried over from the evicted line.
- R9: `pf_valid` is 0 in every cycle in which `miss_valid` is 1. A pending prefetch is offered again once no miss is present.
- R10: While `pf_ready` is 0, a pending prefetch stays offered. A newer prefetch candidate replaces it, and only one is kept.
- R11: With `pf_back`=1 at the time of a miss or of an untracked fill, the line's stored direction is downward and its neighbour is line-1; with 0 it is line+1. A prefetched line inherits the direction of the request that fetched it.
- R12: Neighbour arithmetic wraps modulo 2^LINE_W: line+1 of the top line is 0, and line-1 of line 0 is the top line.
- R13: `inv_valid` removes the line `inv_line` if that exact line is present. A different line at the same index is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Demand access strobe |
| acc_line | input | LINE_W | Line address of the access |
| pf_back | input | 1 | Direction for new streams: 1 selects line-1 |
| fill_valid | input | 1 | Fill response strobe |
| fill_line | input | LINE_W | Line address of the fill |
| fill_is_pf | input | 1 | 1: fill answers a prefetch, 0: a demand |
| fill_err | input | 1 | Fill reports an exception; nothing is installed |
| inv_valid | input | 1 | Line removal strobe |
| inv_line | input | LINE_W | Line to remove |
| res_valid | output | 1 | Access result valid |
| res_hit | output | 1 | Access hit |
| miss_valid | output | 1 | Demand miss request |
| miss_line | output | LINE_W | Line of the demand miss |
| pf_valid | output | 1 | Prefetch request valid |
| pf_line | output | LINE_W | Line to prefetch |
| pf_ready | input | 1 | Memory accepts the prefetch request |

## Verification
The access result and the miss request appear exactly one cycle after the access. A prefetch appears in the cycle after the fill or the hit that armed the line. It disappears in the cycle after it is accepted with `pf_ready` high. Each scenario task drives its stimulus just after a falling edge and samples at the next falling edge, which is the first point where these registered results can be seen. Suppressed prefetches are confirmed absent in that same cycle. Hold, priority and overwrite of the pending request are checked cycle by cycle while `pf_ready` is held low.

// File: rtl/nlp_pkg.sv
package nlp_pkg;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_BWD = 1'b1
    } pf_dir_e;

    localparam int unsigned LINE_W_MAX = 32;

    // Neighbour line in the given direction, wrapped to a width-bit space.
    function automatic logic [LINE_W_MAX-1:0] step_line(
        input logic [LINE_W_MAX-1:0] ln,
        input pf_dir_e               dir,
        input int unsigned           width
    );
        logic [LINE_W_MAX:0]   mask;
        logic [LINE_W_MAX-1:0] raw;
        mask = ((LINE_W_MAX+1)'(1) << width) - (LINE_W_MAX+1)'(1);
        raw  = (dir == DIR_BWD) ? ln - LINE_W_MAX'(1) : ln + LINE_W_MAX'(1);
        return raw & mask[LINE_W_MAX-1:0];
    endfunction

endpackage

// File: rtl/nlp_tag_store.sv
module nlp_tag_store
    import nlp_pkg::*;
#(
    parameter int unsigned LINE_W  = 12,
    parameter int unsigned IDX_W   = 3,
    parameter bit          BACK_EN = 1'b1
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0][LINE_W-1:0] look_line,
    output logic [1:0]             look_hit,
    output logic [1:0]             look_armed,
    output logic [1:0]             look_dir,
    output logic [1:0]             look_nbf,
    output logic [1:0]             look_nbb,
    input  logic                   ins_en,
    input  logic [LINE_W-1:0]      ins_line,
    input  logic                   ins_armed,
    input  logic                   ins_dir,
    input  logic                   arm_en,
    input  logic [IDX_W-1:0]       arm_idx,
    input  logic                   inv_en,
    input  logic [LINE_W-1:0]      inv_line
);
    localparam int SETS  = 1 << IDX_W;
    localparam int TAG_W = LINE_W - IDX_W;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic             armed;
        logic             dir;
    } way_t;

    way_t ways_q [SETS];

    function automatic logic present(input way_t w, input logic [LINE_W-1:0] ln);
        return w.vld && (w.tag == ln[LINE_W-1:IDX_W]);
    endfunction

    for (genvar p = 0; p < 2; p++) begin : g_look
        way_t                self_w;
        way_t                fwd_w;
        logic [LINE_W-1:0]   fwd_ln;
        assign self_w        = ways_q[look_line[p][IDX_W-1:0]];
        assign look_hit[p]   = present(self_w, look_line[p]);
        assign look_armed[p] = self_w.armed;
        assign look_dir[p]   = self_w.dir;
        assign fwd_ln        = LINE_W'(step_line(LINE_W_MAX'(look_line[p]), DIR_FWD, LINE_W));
        assign fwd_w         = ways_q[fwd_ln[IDX_W-1:0]];
        assign look_nbf[p]   = present(fwd_w, fwd_ln);
        if (BACK_EN) begin : g_bwd
            way_t              bwd_w;
            logic [LINE_W-1:0] bwd_ln;
            assign bwd_ln      = LINE_W'(step_line(LINE_W_MAX'(look_line[p]), DIR_BWD, LINE_W));
            assign bwd_w       = ways_q[bwd_ln[IDX_W-1:0]];
            assign look_nbb[p] = present(bwd_w, bwd_ln);
        end else begin : g_no_bwd
            assign look_nbb[p] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SETS; i++) ways_q[i] <= '0;
        end else begin
            for (int i = 0; i < SETS; i++) begin
                if (ins_en && ins_line[IDX_W-1:0] == IDX_W'(i)) begin
                    ways_q[i] <= '{vld: 1'b1, tag: ins_line[LINE_W-1:IDX_W],
                                   armed: ins_armed, dir: ins_dir};
                end else if (inv_en && inv_line[IDX_W-1:0] == IDX_W'(i)
                             && present(ways_q[i], inv_line)) begin
                    ways_q[i] <= '0;
                end else if (arm_en && arm_idx == IDX_W'(i)) begin
                    ways_q[i].armed <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/nlp_out_table.sv
module nlp_out_table
    import nlp_pkg::*;
#(
    parameter int unsigned LINE_W = 12,
    parameter int unsigned DEPTH  = 4
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   alloc_en,
    input  logic [LINE_W-1:0]      alloc_line,
    input  logic                   alloc_dir,
    input  logic                   free_en,
    input  logic [LINE_W-1:0]      free_line,
    input  logic [LINE_W-1:0]      self_line,
    output logic                   self_hit,
    output logic                   self_dir,
    input  logic [1:0][LINE_W-1:0] nb_line,
    output logic [1:0]             nb_fwd,
    output logic [1:0]             nb_bwd,
    output logic                   has_free
);
    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] line;
        logic              dir;
    } flight_t;

    flight_t tab_q [DEPTH];
    logic [DEPTH-1:0] alloc_oh;
    logic [DEPTH-1:0] free_oh;

    always_comb begin
        alloc_oh = '0;
        free_oh  = '0;
        has_free = 1'b0;
        self_hit = 1'b0;
        self_dir = 1'b0;
        for (int i = 0; i < int'(DEPTH); i++) begin
            if (!tab_q[i].vld && !has_free) begin
                alloc_oh[i] = 1'b1;
                has_free    = 1'b1;
            end
            if (tab_q[i].vld && tab_q[i].line == free_line && free_oh == '0)
                free_oh[i] = 1'b1;
            if (tab_q[i].vld && tab_q[i].line == self_line && !self_hit) begin
                self_hit = 1'b1;
                self_dir = tab_q[i].dir;
            end
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_nb
        logic [LINE_W-1:0] fwd_ln;
        logic [LINE_W-1:0] bwd_ln;
        logic              f_hit;
        logic              b_hit;
        assign fwd_ln = LINE_W'(step_line(LINE_W_MAX'(nb_line[p]), DIR_FWD, LINE_W));
        assign bwd_ln = LINE_W'(step_line(LINE_W_MAX'(nb_line[p]), DIR_BWD, LINE_W));
        always_comb begin
            f_hit = 1'b0;
            b_hit = 1'b0;
            for (int i = 0; i < int'(DEPTH); i++) begin
                if (tab_q[i].vld && tab_q[i].line == fwd_ln) f_hit = 1'b1;
                if (tab_q[i].vld && tab_q[i].line == bwd_ln) b_hit = 1'b1;
            end
        end
        assign nb_fwd[p] = f_hit;
        assign nb_bwd[p] = b_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) tab_q[i] <= '0;
        end else begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                if (alloc_en && alloc_oh[i])
                    tab_q[i] <= '{vld: 1'b1, line: alloc_line, dir: alloc_dir};
                else if (free_en && free_oh[i])
                    tab_q[i].vld <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/nlp_pf_slot.sv
module nlp_pf_slot #(
    parameter int unsigned LINE_W = 12
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LINE_W-1:0] load_line,
    input  logic              load_dir,
    input  logic              take,
    output logic              pend,
    output logic [LINE_W-1:0] line,
    output logic              dir
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            line <= '0;
            dir  <= 1'b0;
        end else if (load) begin
            pend <= 1'b1;
            line <= load_line;
            dir  <= load_dir;
        end else if (take) begin
            pend <= 1'b0;
        end
    end
endmodule

// File: rtl/nlp_prefetch.sv
module nlp_prefetch
    import nlp_pkg::*;
#(
    parameter int unsigned LINE_W    = 12,
    parameter int unsigned IDX_W     = 3,
    parameter int unsigned OUT_DEPTH = 4,
    parameter bit          BACK_EN   = 1'b1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [LINE_W-1:0] acc_line,
    input  logic              pf_back,
    input  logic              fill_valid,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              fill_is_pf,
    input  logic              fill_err,
    input  logic              inv_valid,
    input  logic [LINE_W-1:0] inv_line,
    output logic              res_valid,
    output logic              res_hit,
    output logic              miss_valid,
    output logic [LINE_W-1:0] miss_line,
    output logic              pf_valid,
    output logic [LINE_W-1:0] pf_line,
    input  logic              pf_ready
);
    localparam int unsigned P_ACC  = 0;
    localparam int unsigned P_FILL = 1;

    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] line;
        logic              dir;
    } cand_t;

    logic [1:0][LINE_W-1:0] look_line;
    logic [1:0] st_hit, st_armed, st_dir, st_nbf, st_nbb;
    logic [1:0] fl_nbf, fl_nbb;
    logic       fl_self_hit, fl_self_dir, fl_has_free;

    logic       fill_ok, fill_present, fill_dir, fill_rise;
    logic       ins_en, same_idx, acc_hit, acc_rise, arm_en;
    logic       miss_dir_q;
    logic       slot_pend, slot_dir, take;
    logic [LINE_W-1:0] slot_line;
    cand_t      cand_a, cand_f, cand_sel;

    assign look_line = {fill_line, acc_line};

    nlp_tag_store #(.LINE_W(LINE_W), .IDX_W(IDX_W), .BACK_EN(BACK_EN)) u_store (
        .clk(clk), .rst(rst),
        .look_line(look_line), .look_hit(st_hit), .look_armed(st_armed),
        .look_dir(st_dir), .look_nbf(st_nbf), .look_nbb(st_nbb),
        .ins_en(ins_en), .ins_line(fill_line), .ins_armed(!fill_is_pf), .ins_dir(fill_dir),
        .arm_en(arm_en), .arm_idx(acc_line[IDX_W-1:0]),
        .inv_en(inv_valid), .inv_line(inv_line)
    );

    nlp_out_table #(.LINE_W(LINE_W), .DEPTH(OUT_DEPTH)) u_flight (
        .clk(clk), .rst(rst),
        .alloc_en(miss_valid || take),
        .alloc_line(miss_valid ? miss_line : slot_line),
        .alloc_dir(miss_valid ? miss_dir_q : slot_dir),
        .free_en(fill_valid), .free_line(fill_line),
        .self_line(fill_line), .self_hit(fl_self_hit), .self_dir(fl_self_dir),
        .nb_line(look_line), .nb_fwd(fl_nbf), .nb_bwd(fl_nbb),
        .has_free(fl_has_free)
    );

    // Fill side: install, and arm-on-install for demand fills.
    assign fill_ok      = fill_valid && !fill_err;
    assign fill_present = st_hit[P_FILL];
    assign fill_dir     = BACK_EN && (fl_self_hit ? fl_self_dir
                                    : (fill_present ? st_dir[P_FILL] : pf_back));
    assign ins_en       = fill_ok && !(fill_is_pf && fill_present);
    assign fill_rise    = fill_ok && !fill_is_pf && !(fill_present && st_armed[P_FILL]);

    // Access side: a hit on an unarmed line arms it.
    assign same_idx = ins_en && (fill_line[IDX_W-1:0] == acc_line[IDX_W-1:0]);
    assign acc_hit  = acc_valid && st_hit[P_ACC];
    assign arm_en   = acc_hit && !same_idx;
    assign acc_rise = arm_en && !st_armed[P_ACC];

    function automatic cand_t make_cand(
        input logic              rise,
        input logic [LINE_W-1:0] base,
        input logic              dir,
        input logic              nb_in_cache_f,
        input logic              nb_in_cache_b,
        input logic              nb_in_flight_f,
        input logic              nb_in_flight_b,
        input logic              spend,
        input logic [LINE_W-1:0] sline
    );
        cand_t c;
        c.dir  = dir;
        c.line = LINE_W'(step_line(LINE_W_MAX'(base), pf_dir_e'(dir), LINE_W));
        c.vld  = rise
              && !(dir ? nb_in_cache_b  : nb_in_cache_f)
              && !(dir ? nb_in_flight_b : nb_in_flight_f)
              && !(spend && sline == c.line);
        return c;
    endfunction

    always_comb begin
        cand_a   = make_cand(acc_rise, acc_line, BACK_EN && st_dir[P_ACC],
                             st_nbf[P_ACC], st_nbb[P_ACC], fl_nbf[P_ACC], fl_nbb[P_ACC],
                             slot_pend, slot_line);
        cand_f   = make_cand(fill_rise, fill_line, fill_dir,
                             st_nbf[P_FILL], st_nbb[P_FILL], fl_nbf[P_FILL], fl_nbb[P_FILL],
                             slot_pend, slot_line);
        cand_sel = cand_a.vld ? cand_a : cand_f;
    end

    nlp_pf_slot #(.LINE_W(LINE_W)) u_slot (
        .clk(clk), .rst(rst),
        .load(cand_sel.vld), .load_line(cand_sel.line), .load_dir(cand_sel.dir),
        .take(take),
        .pend(slot_pend), .line(slot_line), .dir(slot_dir)
    );

    assign pf_valid = slot_pend && !miss_valid && fl_has_free;
    assign pf_line  = slot_line;
    assign take     = pf_valid && pf_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_hit    <= 1'b0;
            miss_valid <= 1'b0;
            miss_line  <= '0;
            miss_dir_q <= 1'b0;
        end else begin
            res_valid  <= acc_valid;
            res_hit    <= acc_hit;
            miss_valid <= acc_valid && !acc_hit;
            miss_line  <= acc_line;
            miss_dir_q <= BACK_EN && pf_back;
        end
    end
endmodule

// File: rtl/nlp_prefetch_chk.sv
module nlp_prefetch_chk (
    input logic clk,
    input logic rst,
    input logic acc_valid,
    input logic res_valid,
    input logic res_hit,
    input logic miss_valid,
    input logic pf_valid,
    input logic pf_ready
);
    AST_QUIET_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!res_valid && !miss_valid && !pf_valid)); // R1
    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> res_valid); // R2
    AST_MISS_HAS_ACCESS: assert property (@(posedge clk) disable iff (rst)
        miss_valid |-> $past(acc_valid)); // R2
    AST_HIT_NO_MISS: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_hit) |-> !miss_valid); // R2
    AST_DEMAND_FIRST: assert property (@(posedge clk) disable iff (rst)
        miss_valid |-> !pf_valid); // R9
    AST_PF_HELD: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && !pf_ready) |=> (pf_valid || miss_valid)); // R10
endmodule

bind nlp_prefetch nlp_prefetch_chk u_chk (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .res_valid(res_valid),
    .res_hit(res_hit), .miss_valid(miss_valid), .pf_valid(pf_valid), .pf_ready(pf_ready)
);

// File: tb/nlp_prefetch_bench.sv
`timescale 1ns/1ps
module nlp_prefetch_bench;
    localparam int unsigned LW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_valid = 1'b0;
    logic [LW-1:0] acc_line = '0;
    logic          pf_back = 1'b0;
    logic          fill_valid = 1'b0;
    logic [LW-1:0] fill_line = '0;
    logic          fill_is_pf = 1'b0;
    logic          fill_err = 1'b0;
    logic          inv_valid = 1'b0;
    logic [LW-1:0] inv_line = '0;
    logic          pf_ready = 1'b1;
    logic          res_valid, res_hit, miss_valid, pf_valid;
    logic [LW-1:0] miss_line, pf_line;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    nlp_prefetch #(.LINE_W(LW), .IDX_W(3), .OUT_DEPTH(4), .BACK_EN(1'b1)) u_nlp_prefetch (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_line(acc_line),
        .pf_back(pf_back), .fill_valid(fill_valid), .fill_line(fill_line),
        .fill_is_pf(fill_is_pf), .fill_err(fill_err), .inv_valid(inv_valid),
        .inv_line(inv_line), .res_valid(res_valid), .res_hit(res_hit),
        .miss_valid(miss_valid), .miss_line(miss_line), .pf_valid(pf_valid),
        .pf_line(pf_line), .pf_ready(pf_ready)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; pf_ready = 1'b1; pf_back = 1'b0;
        acc_valid = 1'b0; fill_valid = 1'b0; inv_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic access(input logic [LW-1:0] ln);
        acc_valid = 1'b1; acc_line = ln;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic fill(input logic [LW-1:0] ln, input logic is_pf, input logic err);
        fill_valid = 1'b1; fill_line = ln; fill_is_pf = is_pf; fill_err = err;
        @(negedge clk);
        fill_valid = 1'b0; fill_err = 1'b0;
    endtask

    task automatic inval(input logic [LW-1:0] ln);
        inv_valid = 1'b1; inv_line = ln;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic t_miss_then_fill();
        do_reset();
        chk("R1", "res_valid", res_valid, 0);
        chk("R1", "miss_valid", miss_valid, 0);
        chk("R1", "pf_valid", pf_valid, 0);
        access(12'h010);
        chk("R2", "res_valid", res_valid, 1);
        chk("R2", "res_hit", res_hit, 0);
        chk("R2", "miss_valid", miss_valid, 1);
        chk("R2", "miss_line", miss_line, 12'h010);
        idle();
        chk("R2", "miss pulse end", miss_valid, 0);
        fill(12'h010, 1'b0, 1'b0);
        chk("R3", "pf_valid", pf_valid, 1);
        chk("R3", "pf_line", pf_line, 12'h011);
        idle();
        chk("R3", "pf taken", pf_valid, 0);
        access(12'h010);
        chk("R2", "res_hit", res_hit, 1);
        chk("R2", "no miss on hit", miss_valid, 0);
        chk("R4", "armed line no pf", pf_valid, 0);
    endtask

    task automatic t_chain();
        do_reset();
        fill(12'h011, 1'b1, 1'b0);
        chk("R4", "pf fill no pf", pf_valid, 0);
        access(12'h011);
        chk("R4", "first hit hit", res_hit, 1);
        chk("R4", "first hit pf", pf_valid, 1);
        chk("R4", "first hit pf_line", pf_line, 12'h012);
        idle();
        access(12'h011);
        chk("R4", "second hit no pf", pf_valid, 0);
    endtask

    task automatic t_present();
        do_reset();
        fill(12'h023, 1'b1, 1'b0);
        fill(12'h022, 1'b0, 1'b0);
        chk("R5", "neighbour present", pf_valid, 0);
        fill(12'h024, 1'b0, 1'b0);
        chk("R3", "control pf", pf_valid, 1);
        chk("R3", "control pf_line", pf_line, 12'h025);
    endtask

    task automatic t_flight_and_err();
        do_reset();
        fill(12'h030, 1'b0, 1'b0);
        chk("R6", "first pf", pf_line, 12'h031);
        idle();
        inval(12'h030);
        fill(12'h030, 1'b0, 1'b0);
        chk("R6", "in flight suppressed", pf_valid, 0);
        fill(12'h031, 1'b1, 1'b1);
        chk("R7", "err fill no pf", pf_valid, 0);
        inval(12'h030);
        fill(12'h030, 1'b0, 1'b0);
        chk("R6", "freed by err fill", pf_valid, 1);
        chk("R6", "freed pf_line", pf_line, 12'h031);
        idle();
        access(12'h031);
        chk("R7", "err fill installed nothing", res_hit, 0);
        chk("R7", "miss issued", miss_valid, 1);
    endtask

    task automatic t_priority_overwrite();
        do_reset();
        pf_ready = 1'b0;
        fill(12'h040, 1'b0, 1'b0);
        chk("R10", "offered", pf_valid, 1);
        idle();
        chk("R10", "held", pf_valid, 1);
        chk("R10", "held line", pf_line, 12'h041);
        access(12'h050);
        chk("R9", "miss present", miss_valid, 1);
        chk("R9", "pf yields", pf_valid, 0);
        idle();
        chk("R9", "pf back", pf_valid, 1);
        chk("R9", "pf back line", pf_line, 12'h041);
        fill(12'h060, 1'b0, 1'b0);
        chk("R10", "overwritten line", pf_line, 12'h061);
        pf_ready = 1'b1;
        idle();
        chk("R10", "single slot drained", pf_valid, 0);
    endtask

    task automatic t_replace();
        do_reset();
        fill(12'h080, 1'b0, 1'b0);
        chk("R3", "pf 081", pf_line, 12'h081);
        idle();
        fill(12'h088, 1'b1, 1'b0);
        chk("R8", "pf fill no pf", pf_valid, 0);
        access(12'h080);
        chk("R8", "old line evicted", res_hit, 0);
        access(12'h088);
        chk("R8", "new line hit", res_hit, 1);
        chk("R8", "new line unarmed", pf_valid, 1);
        chk("R8", "pf_line", pf_line, 12'h089);
    endtask

    task automatic t_backward();
        do_reset();
        pf_back = 1'b1;
        fill(12'h090, 1'b0, 1'b0);
        chk("R11", "bwd pf", pf_valid, 1);
        chk("R11", "bwd pf_line", pf_line, 12'h08F);
        idle();
        fill(12'h08F, 1'b1, 1'b0);
        pf_back = 1'b0;
        access(12'h08F);
        chk("R11", "inherited bwd", pf_line, 12'h08E);
        idle();
        fill(12'h0B0, 1'b0, 1'b0);
        chk("R11", "fwd pf_line", pf_line, 12'h0B1);
    endtask

    task automatic t_wrap();
        do_reset();
        pf_back = 1'b1;
        fill(12'h000, 1'b0, 1'b0);
        chk("R12", "wrap down", pf_line, 12'hFFF);
        do_reset();
        fill(12'hFFF, 1'b0, 1'b0);
        chk("R12", "wrap up valid", pf_valid, 1);
        chk("R12", "wrap up", pf_line, 12'h000);
    endtask

    task automatic t_inval();
        do_reset();
        fill(12'h0A0, 1'b0, 1'b0);
        idle();
        inval(12'h0A8);
        access(12'h0A0);
        chk("R13", "other line kept", res_hit, 1);
        inval(12'h0A0);
        access(12'h0A0);
        chk("R13", "removed", res_hit, 0);
        chk("R13", "miss after remove", miss_valid, 1);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        t_miss_then_fill();
        t_chain();
        t_present();
        t_flight_and_err();
        t_priority_overwrite();
        t_replace();
        t_backward();
        t_wrap();
        t_inval();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule